// File: doc/BRIEF.md
# Microsecond System Timer with Compare Channels

This peripheral sits on a simple 32-bit register bus. It keeps a 64-bit count of microseconds since reset. A prescaler divides the system clock down to one tick per microsecond. Software reads the count as two 32-bit words, one for the lower half and one for the upper half.

Four 32-bit compare channels watch the lower half of the count. When the count reaches the value held in a channel, that channel raises a sticky status bit. Software clears a status bit by writing a one to it. The interrupt line is high while any status bit is set.

Bus accesses are single 32-bit words in little-endian order within a 32-byte window. The read data and the error flag for an access are registered and appear on the cycle after the access. An access the block cannot serve returns zero, raises the error flag and changes nothing.

Top module: `sys_timer_top`

## Requirements
- R1: After reset, the following all read as zero: the status word, all four compare registers and the counter. The interrupt output is low.
- R2: The counter advances by exactly one every CLK_HZ/TICK_HZ clock cycles and never moves between ticks. Counting starts from the first clock edge without reset.
- R3: A read of byte offset 0x04 returns counter bits 31:0. A read of byte offset 0x08 returns counter bits 63:32.
- R4: A write to offset 0x04 or 0x08 raises the error flag and leaves the counter unchanged.
- R5: Compare channel n is read/write storage at byte offset 0x0C + 4·n, for n = 0 to 3.
- R6: Status bit n sets on the clock edge where counter bits 31:0 take the value of compare channel n. The bit stays set until it is acknowledged. Bits of other channels are not affected.
- R7: A write to offset 0x00 clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged. A read of offset 0x00 returns the four status bits in bits 3:0, with zeros above them.
- R8: If a match for channel n happens on the same edge that acknowledges bit n, the bit ends up set.
- R9: The interrupt output is high exactly when at least one status bit is set. It falls only after a write to the status word.
- R10: The following accesses return read data zero, raise the error flag and change no state: offset 0x1C, any offset with address bits 1:0 nonzero, and any access whose byte enables are not all four set.
- R11: Read data and the error flag for an access are valid on the cycle after the access and are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the 32-byte window |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Error flag, one cycle after the access |
| irq | output | 1 | High while any status bit is set |

## Verification
Two cases are hard to bring about from the ports. The first is a compare match on an exact clock edge. The second is a match that lands on the same edge as an acknowledge write.

The bench runs the block with a divide ratio of four. It keeps its own count of clock edges since reset, so the edge at which the counter reaches a value V is known arithmetically as 4·V. The bench places a compare value a few ticks ahead of the current count and waits until the cycle before that edge. It then issues a status read that lands exactly on the edge, followed by a second read, and checks that the bit is clear in the first and set in the second. In a separate case it issues an acknowledge write that lands on the match edge.

// File: rtl/systmr_pkg.sv
// Package: shared constants for the microsecond system timer.
// Assumes a 32-byte window decoded as eight 32-bit words.
package systmr_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned NUM_CMP = 4;
    localparam int unsigned CNT_W   = 64;

    // Word indices (byte offset / 4)
    localparam logic [2:0] W_STATUS = 3'd0;
    localparam logic [2:0] W_CNT_LO = 3'd1;
    localparam logic [2:0] W_CNT_HI = 3'd2;
    localparam logic [2:0] W_CMP0   = 3'd3;
    localparam logic [2:0] W_HOLE   = 3'd7;
endpackage

// File: rtl/us_tick_gen.sv
// Module: us_tick_gen
// Emits a one-cycle tick every DIV clock cycles.
// Assumes DIV >= 1. The first tick appears DIV cycles after reset is released.
module us_tick_gen #(
    parameter int unsigned DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    // Cycle the phase counter through 0 .. DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else if (tick) phase_q <= '0;
        else phase_q <= phase_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2: two ticks are never back to back when the ratio exceeds one
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/usec_counter.sv
// Module: usec_counter
// Free-running W-bit counter that advances on each tick.
// Also gives the low LO_W bits of the value the counter will hold after the next tick.
module usec_counter #(
    parameter int unsigned W    = 64,
    parameter int unsigned LO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [W-1:0]    cnt,
    output logic [LO_W-1:0] nxt_lo
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;
    assign cnt     = cnt_q;
    assign nxt_lo  = cnt_inc[LO_W-1:0];

    // Advance the count once per tick
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_inc;
    end

    // R2: the count steps by one on a tick
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R2: the count holds between ticks
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_bank.sv
// Module: cmp_bank
// Holds N compare registers and N sticky status bits.
// A status bit sets when the next count value equals its compare value on a tick.
// A status bit clears when its bit is set in the acknowledge mask.
// Set wins over clear on the same edge.
module cmp_bank #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] nxt_lo,
    input  logic [N-1:0] wr_en,
    input  logic [W-1:0] wdata,
    input  logic [N-1:0] ack_mask,
    output logic [N*W-1:0] cmp_flat,
    output logic [N-1:0] status
);
    logic [N-1:0] hit;
    logic [N-1:0] status_q;

    generate
        for (genvar n = 0; n < N; n++) begin : g_ch
            logic [W-1:0] cmp_q;

            // Store the compare value written by the bus
            always_ff @(posedge clk) begin
                if (!rst_n) cmp_q <= '0;
                else if (wr_en[n]) cmp_q <= wdata;
            end

            assign hit[n] = tick && (nxt_lo == cmp_q);
            assign cmp_flat[n*W +: W] = cmp_q;
        end
    endgenerate

    // Merge acknowledges and new matches into the sticky status
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else status_q <= (status_q & ~ack_mask) | hit;
    end

    assign status = status_q;

    // R6, R8: every match leaves its bit set
    p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));
    // R7: bits that are not acknowledged stay set
    p_unacked_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~ack_mask)) == $past(status_q & ~ack_mask)));
endmodule

// File: rtl/sys_timer_top.sv
// Module: sys_timer_top
// Microsecond system timer with four compare channels on a 32-bit register bus.
// Assumes CLK_HZ is an integer multiple of TICK_HZ.
// Read data and the error flag are registered and valid one cycle after the access.
module sys_timer_top #(
    parameter int unsigned CLK_HZ  = 250_000_000,
    parameter int unsigned TICK_HZ = 1_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    output logic        irq
);
    import systmr_pkg::*;

    localparam int unsigned DIV = CLK_HZ / TICK_HZ;

    logic                      tick;
    logic [CNT_W-1:0]          cnt;
    logic [DATA_W-1:0]         nxt_lo;
    logic [NUM_CMP*DATA_W-1:0] cmp_flat;
    logic [NUM_CMP-1:0]        status;
    logic [NUM_CMP-1:0]        cmp_wr;
    logic [NUM_CMP-1:0]        ack_mask;
    logic [2:0]                word;
    logic                      acc_ok;
    logic                      stat_wr;
    logic                      err_d;
    logic [DATA_W-1:0]         rd_d;
    logic [DATA_W-1:0]         rdata_q;
    logic                      err_q;

    us_tick_gen #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    usec_counter #(.W(CNT_W), .LO_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .nxt_lo(nxt_lo)
    );

    cmp_bank #(.N(NUM_CMP), .W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nxt_lo(nxt_lo),
        .wr_en(cmp_wr), .wdata(bus_wdata), .ack_mask(ack_mask),
        .cmp_flat(cmp_flat), .status(status)
    );

    assign word    = bus_addr[4:2];
    assign acc_ok  = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
    assign stat_wr = acc_ok && bus_we && (word == W_STATUS);
    assign ack_mask = stat_wr ? bus_wdata[NUM_CMP-1:0] : '0;

    // Decode the compare write strobes
    always_comb begin
        for (int n = 0; n < NUM_CMP; n++)
            cmp_wr[n] = acc_ok && bus_we && (word == 3'(W_CMP0 + n));
    end

    // Flag accesses that cannot be served
    always_comb begin
        err_d = bus_sel && (!acc_ok || (word == W_HOLE) ||
                (bus_we && (word == W_CNT_LO || word == W_CNT_HI)));
    end

    // Select the read data for a good read
    always_comb begin
        rd_d = '0;
        if (acc_ok && !bus_we) begin
            if (word == W_STATUS) rd_d = DATA_W'(status);
            else if (word == W_CNT_LO) rd_d = cnt[DATA_W-1:0];
            else if (word == W_CNT_HI) rd_d = cnt[CNT_W-1:DATA_W];
            for (int n = 0; n < NUM_CMP; n++)
                if (word == 3'(W_CMP0 + n)) rd_d = cmp_flat[n*DATA_W +: DATA_W];
        end
    end

    // Register the response for the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rd_d;
            err_q   <= err_d;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign irq       = |status;

    // R9: the interrupt only drops after a status write
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_wr));
    // R10: an access to the hole raises the error flag next cycle
    p_hole_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && word == W_HOLE) |=> bus_err);
    // R11: no response data without a preceding access
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (bus_rdata == '0 && !bus_err));
endmodule

// File: tb/sys_timer_top_tb.sv
// Bench for sys_timer_top, run with a divide ratio of 4.
module sys_timer_top_tb;
    localparam int unsigned DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int ecnt = 0;
    bit done = 0;

    sys_timer_top #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    always #2 clk = ~clk;

    // Count the clock edges since reset was released
    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else ecnt <= ecnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus access; starts and ends at a falling edge
    task automatic access(input logic we, input logic [4:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd = bus_rdata;
        er = bus_err;
    endtask

    task automatic wait_to(input int t);
        while (ecnt != t) @(negedge clk);
    endtask

    function automatic logic [31:0] cnt_at(input int e);
        return 32'((e - 1) / DIV);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er;
        int e;
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 32'(irq), 32'd0);
        access(0, 5'h00, 4'hF, 0, rd, er); check("R1 status", rd, 0);
        for (int n = 0; n < 4; n++) begin
            access(0, 5'(12 + 4 * n), 4'hF, 0, rd, er); check("R1 cmp", rd, 0);
        end
        access(0, 5'h04, 4'hF, 0, rd, er); check("R1 counter low", rd, cnt_at(ecnt));

        // R2, R3: consecutive reads sweep every prescaler phase
        for (int k = 0; k < 12; k++) begin
            access(0, 5'h04, 4'hF, 0, rd, er); check("R2 R3 low word", rd, cnt_at(ecnt));
        end
        access(0, 5'h08, 4'hF, 0, rd, er); check("R3 high word", rd, 0);
        check("R11 no err on good read", 32'(er), 0);
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 0);

        // R4: counter writes ignored
        access(1, 5'h04, 4'hF, 32'hFFFF_0000, rd, er); check("R4 err low", 32'(er), 1);
        access(1, 5'h08, 4'hF, 32'h1234_5678, rd, er); check("R4 err high", 32'(er), 1);
        access(0, 5'h04, 4'hF, 0, rd, er); check("R4 low unchanged", rd, cnt_at(ecnt));
        access(0, 5'h08, 4'hF, 0, rd, er); check("R4 high unchanged", rd, 0);

        // R5: compare storage sweep
        for (int n = 0; n < 4; n++)
            access(1, 5'(12 + 4 * n), 4'hF, 32'hA000_0000 ^ (32'h0111_1111 * n), rd, er);
        for (int n = 0; n < 4; n++) begin
            access(0, 5'(12 + 4 * n), 4'hF, 0, rd, er);
            check("R5 cmp readback", rd, 32'hA000_0000 ^ (32'h0111_1111 * n));
        end

        // R10: bad accesses
        access(0, 5'h1C, 4'hF, 0, rd, er);
        check("R10 hole data", rd, 0); check("R10 hole err", 32'(er), 1);
        access(0, 5'h0D, 4'hF, 0, rd, er);
        check("R10 unaligned data", rd, 0); check("R10 unaligned err", 32'(er), 1);
        access(1, 5'h10, 4'h3, 32'h0, rd, er); check("R10 partial err", 32'(er), 1);
        access(0, 5'h10, 4'hF, 0, rd, er); check("R10 partial ignored", rd, 32'hA111_1111);

        // R6, R9: exact match edge for each channel
        for (int n = 0; n < 4; n++) begin
            v = int'(cnt_at(ecnt)) + 6;
            e = v * DIV;
            access(1, 5'(12 + 4 * n), 4'hF, 32'(v), rd, er);
            wait_to(e - 1);
            check("R9 irq before match", 32'(irq), 0);
            access(0, 5'h00, 4'hF, 0, rd, er); check("R6 before edge", rd, 0);
            check("R9 irq after match", 32'(irq), 1);
            access(0, 5'h00, 4'hF, 0, rd, er); check("R6 bit set", rd, 32'(1 << n));
            // R7: write zero leaves bit, write one clears it
            access(1, 5'h00, 4'hF, 32'h0, rd, er);
            access(0, 5'h00, 4'hF, 0, rd, er); check("R7 zero keeps", rd, 32'(1 << n));
            access(1, 5'h00, 4'hF, 32'(1 << n), rd, er);
            check("R9 irq cleared", 32'(irq), 0);
            access(0, 5'h00, 4'hF, 0, rd, er); check("R7 one clears", rd, 0);
        end

        // R7: selective clear with two bits set
        v = int'(cnt_at(ecnt)) + 6;
        access(1, 5'h0C, 4'hF, 32'(v), rd, er);
        access(1, 5'h18, 4'hF, 32'(v), rd, er);
        wait_to(v * DIV + 1);
        access(0, 5'h00, 4'hF, 0, rd, er); check("R6 two bits", rd, 32'h9);
        access(1, 5'h00, 4'hF, 32'h1, rd, er);
        access(0, 5'h00, 4'hF, 0, rd, er); check("R7 selective", rd, 32'h8);
        check("R9 irq one bit", 32'(irq), 1);
        access(1, 5'h00, 4'hF, 32'hF, rd, er);

        // R8: acknowledge on the match edge
        v = int'(cnt_at(ecnt)) + 6;
        access(1, 5'h14, 4'hF, 32'(v), rd, er);
        wait_to(v * DIV - 1);
        access(1, 5'h00, 4'hF, 32'h4, rd, er);
        access(0, 5'h00, 4'hF, 0, rd, er); check("R8 set wins", rd, 32'h4);
        check("R8 irq", 32'(irq), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule